// File: doc/BRIEF.md
# UART Receive/Transmit Hardware Flow Control

This block adds automatic RTS/CTS handshaking to a single UART channel whose receive FIFO holds 64 bytes. On the receive side it watches the FIFO fill count and drives the request-to-send pin. It deasserts RTS once the fill count reaches a programmable halt level. It asserts RTS again only after the fill count has dropped to a separate, lower resume level. The band between the two levels stops RTS from chattering while the host drains the FIFO.

On the transmit side it synchronizes the incoming clear-to-send pin and gives the transmitter a grant to start its next character. The grant is only examined while the transmitter sits idle between characters. A character that is already being shifted out is therefore never cut short when CTS goes inactive; only the next start is held back.

An 8-bit trigger word carries both levels as 4-bit codes, each scaled by four. Either automatic function can be switched off independently. With automatic RTS off, the pin follows a software request bit. With automatic CTS off, the transmitter is always granted.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is asserted, rts_n is 1 (inactive) and the hysteresis state is cleared. With automatic CTS enabled, tx_grant is 0 until a synchronized active CTS has been seen.
- R2: The halt level is 4 × trig_ctrl[3:0] and the resume level is 4 × trig_ctrl[7:4]. With auto_rts_en = 1 and rx_level below the halt level and at or below the resume level, rts_n is 0 after the next rising clock edge.
- R3: With auto_rts_en = 1 and rx_level at or above the halt level, rts_n is 1 after the next rising clock edge.
- R4: Once halted, with resume level below halt level, rts_n stays 1 while rx_level is above the resume level. It returns to 0 on the edge after rx_level is at or below the resume level.
- R5: When the resume level is not below the halt level, rts_n is 1 exactly when the previous cycle's rx_level was at or above the halt level. No hysteresis applies in this case.
- R6: With auto_rts_en = 0, rts_n equals the inverse of sw_rts from the previous cycle. The hysteresis state is cleared, so re-enabling with rx_level below both levels asserts RTS on the next edge.
- R7: cts_n passes through a two-flop synchronizer. A change on cts_n reaches tx_grant after the second rising edge.
- R8: With auto_cts_en = 1, tx_grant is 1 only when tx_idle = 1 and the synchronized CTS is active (cts_n sampled low). A CTS drop while tx_idle = 0 does not end the running character; only the next start is held off.
- R9: With auto_cts_en = 0, tx_grant is 1 regardless of tx_idle and cts_n.
- R10: A halt code of 0 (halt level 0) keeps rts_n at 1 whenever automatic RTS is enabled, for every fill level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| trig_ctrl | input | 8 | [3:0] halt code, [7:4] resume code, each scaled by 4 |
| auto_rts_en | input | 1 | Enable automatic RTS from FIFO level |
| auto_cts_en | input | 1 | Enable CTS gating of transmit starts |
| sw_rts | input | 1 | Software RTS request (1 = assert) used when automatic RTS is off |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_idle | input | 1 | Transmitter is between characters |
| rts_n | output | 1 | Request-to-send pin, active low, registered |
| tx_grant | output | 1 | Transmitter may start the next character |

## Verification
The fill count is swept upward and then downward through a halt/resume band. This separates the halt comparison from the hysteresis hold, because a design without the band would reassert RTS as soon as the count dropped below halt. A second sweep with resume at or above halt shows the band collapsing to a single threshold. A halt code of zero pins RTS inactive. Toggling the automatic enable while halted exposes whether the hysteresis state really clears. CTS is pulsed against both idle and busy transmitter states to tell the two-edge synchronizer delay apart from character-boundary gating. A long pseudo-random run mixes all inputs against the cycle reference model.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  // Trigger word split into its two codes; resume occupies the upper nibble.
  typedef struct packed {
    logic [3:0] resume_code;
    logic [3:0] halt_code;
  } trig_word_t;

  // Hysteresis state of the receive side.
  typedef enum logic {
    RX_OPEN   = 1'b0,
    RX_HALTED = 1'b1
  } rx_gate_e;

endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  output logic cts_ok
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Stage 0 captures the active-high form of the pin; later stages shift.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb chain_d[g] = ~cts_n;
      end else begin : g_rest
        always_comb chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign cts_ok = chain_q[STAGES-1];

endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst
  import uart_fc_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int CODE_W = 4,
  parameter int SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [CODE_W-1:0] halt_code,
  input  logic [CODE_W-1:0] resume_code,
  input  logic              auto_en,
  input  logic              sw_rts,
  output logic              rts_active
);

  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;
  logic             at_halt;
  logic             at_resume;
  logic             band_ok;
  rx_gate_e         gate_q;
  rx_gate_e         gate_d;
  logic             rts_q;
  logic             rts_d;
  logic             upd_en;

  always_comb begin
    halt_lvl   = LVL_W'(halt_code) << SHIFT;
    resume_lvl = LVL_W'(resume_code) << SHIFT;
    at_halt    = (rx_level >= halt_lvl);
    at_resume  = (rx_level <= resume_lvl);
    band_ok    = (resume_lvl < halt_lvl);
  end

  // Next-state logic for the hysteresis gate.
  always_comb begin
    gate_d = gate_q;
    if (!auto_en) begin
      gate_d = RX_OPEN;
    end else if (!band_ok) begin
      gate_d = at_halt ? RX_HALTED : RX_OPEN;
    end else if (at_halt) begin
      gate_d = RX_HALTED;
    end else if (at_resume) begin
      gate_d = RX_OPEN;
    end
  end

  always_comb begin
    rts_d  = auto_en ? (gate_d == RX_OPEN) : sw_rts;
    upd_en = (gate_d != gate_q) || (rts_d != rts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= RX_OPEN;
      rts_q  <= 1'b0;
    end else if (upd_en) begin
      gate_q <= gate_d;
      rts_q  <= rts_d;
    end
  end

  assign rts_active = rts_q;

endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic auto_cts_en,
  input  logic cts_ok,
  input  logic tx_idle,
  output logic tx_grant
);

  // Starts are only allowed at a character boundary; a running character
  // is never aborted because the gate is consulted only while idle.
  always_comb begin
    if (!auto_cts_en) begin
      tx_grant = 1'b1;
    end else begin
      tx_grant = tx_idle & cts_ok;
    end
  end

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int CODE_W      = 4,
  parameter int LVL_SHIFT   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int TRIG_W     = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [TRIG_W-1:0] trig_ctrl,
  input  logic              auto_rts_en,
  input  logic              auto_cts_en,
  input  logic              sw_rts,
  input  logic              cts_n,
  input  logic              tx_idle,
  output logic              rts_n,
  output logic              tx_grant
);

  logic rts_active;
  logic cts_ok;

  fc_rts_hyst #(
    .LVL_W (LVL_W),
    .CODE_W(CODE_W),
    .SHIFT (LVL_SHIFT)
  ) u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_level   (rx_level),
    .halt_code  (trig_ctrl[CODE_W-1:0]),
    .resume_code(trig_ctrl[TRIG_W-1:CODE_W]),
    .auto_en    (auto_rts_en),
    .sw_rts     (sw_rts),
    .rts_active (rts_active)
  );

  fc_cts_sync #(
    .STAGES(SYNC_STAGES)
  ) u_cts (
    .clk   (clk),
    .rst_n (rst_n),
    .cts_n (cts_n),
    .cts_ok(cts_ok)
  );

  fc_tx_gate u_gate (
    .auto_cts_en(auto_cts_en),
    .cts_ok     (cts_ok),
    .tx_idle    (tx_idle),
    .tx_grant   (tx_grant)
  );

  assign rts_n = ~rts_active;

endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
  parameter int LVL_W     = 7,
  parameter int CODE_W    = 4,
  parameter int LVL_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  rx_level,
  input logic [2*CODE_W-1:0] trig_ctrl,
  input logic              auto_rts_en,
  input logic              auto_cts_en,
  input logic              sw_rts,
  input logic              tx_idle,
  input logic              rts_n,
  input logic              tx_grant
);

  logic [LVL_W-1:0] c_halt;
  logic [LVL_W-1:0] c_res;
  logic             auto_q;

  assign c_halt = LVL_W'(trig_ctrl[CODE_W-1:0]) << LVL_SHIFT;
  assign c_res  = LVL_W'(trig_ctrl[2*CODE_W-1:CODE_W]) << LVL_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) auto_q <= 1'b0;
    else        auto_q <= auto_rts_en;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rts_in_reset_chk: assert (rts_n == 1'b1);
    end
  end

  // R2
  rts_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level < c_halt && rx_level <= c_res) |=> !rts_n);

  // R3
  rts_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= c_halt) |=> rts_n);

  // R4
  rts_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && auto_q && rts_n && c_res < c_halt &&
     rx_level > c_res) |=> rts_n);

  // R6
  rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(sw_rts)));

  // R8
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && tx_grant) |-> tx_idle);

  // R9
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_grant);

endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(
  .LVL_W    (LVL_W),
  .CODE_W   (CODE_W),
  .LVL_SHIFT(LVL_SHIFT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_level   (rx_level),
  .trig_ctrl  (trig_ctrl),
  .auto_rts_en(auto_rts_en),
  .auto_cts_en(auto_cts_en),
  .sw_rts     (sw_rts),
  .tx_idle    (tx_idle),
  .rts_n      (rts_n),
  .tx_grant   (tx_grant)
);

// File: tb/uart_flow_ctrl_test.sv
`timescale 1ns/1ps
module uart_flow_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic [6:0] rx_level;
  logic [7:0] trig_ctrl;
  logic       auto_rts_en;
  logic       auto_cts_en;
  logic       sw_rts;
  logic       cts_n;
  logic       tx_idle;
  logic       rts_n;
  logic       tx_grant;

  int total;
  int bad;
  bit done;

  // reference model state
  bit m_halted;
  bit m_rts;
  bit m_s0, m_s1;

  uart_flow_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_level   (rx_level),
    .trig_ctrl  (trig_ctrl),
    .auto_rts_en(auto_rts_en),
    .auto_cts_en(auto_cts_en),
    .sw_rts     (sw_rts),
    .cts_n      (cts_n),
    .tx_idle    (tx_idle),
    .rts_n      (rts_n),
    .tx_grant   (tx_grant)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: levels in integers, hysteresis as a flag.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halted = 0; m_rts = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      int hl, rl, lv;
      hl = trig_ctrl[3:0] * 4;
      rl = trig_ctrl[7:4] * 4;
      lv = rx_level;
      if (!auto_rts_en) begin
        m_halted = 0;
        m_rts = sw_rts;
      end else begin
        if (rl >= hl)      m_halted = (lv >= hl);
        else if (lv >= hl) m_halted = 1;
        else if (lv <= rl) m_halted = 0;
        m_rts = !m_halted;
      end
      m_s1 = m_s0;
      m_s0 = !cts_n;
    end
  end

  task automatic compare(string tag);
    bit exp_rts_n, exp_grant;
    exp_rts_n = !m_rts;
    exp_grant = !auto_cts_en || (tx_idle && m_s1);
    total++;
    if (rts_n !== exp_rts_n) begin
      bad++;
      $display("FAIL %s rts_n lvl=%0d trig=%h actual=%b expected=%b",
               tag, rx_level, trig_ctrl, rts_n, exp_rts_n);
    end
    total++;
    if (tx_grant !== exp_grant) begin
      bad++;
      $display("FAIL %s tx_grant actual=%b expected=%b", tag, tx_grant, exp_grant);
    end
  endtask

  task automatic cyc(int lvl, logic [7:0] trg, bit ar, bit ac, bit sw,
                     bit cn, bit idle, string tag);
    rx_level = 7'(lvl); trig_ctrl = trg; auto_rts_en = ar; auto_cts_en = ac;
    sw_rts = sw; cts_n = cn; tx_idle = idle;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    total = 0; bad = 0; done = 0;
    rst_n = 0;
    rx_level = 0; trig_ctrl = 8'h48; auto_rts_en = 1; auto_cts_en = 1;
    sw_rts = 1; cts_n = 0; tx_idle = 1;
    // R1: reset state held for several cycles
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1;
    cyc(0, 8'h48, 0, 1, 0, 1, 1, "R1");

    // R2: halt 32, resume 16, low level asserts RTS
    cyc(10, 8'h48, 1, 0, 0, 1, 1, "R2");
    cyc(10, 8'h48, 1, 0, 0, 1, 1, "R2");
    // R3: ramp up through halt level
    for (int l = 10; l <= 46; l += 3) cyc(l, 8'h48, 1, 0, 0, 1, 1, "R3");
    cyc(32, 8'h48, 1, 0, 0, 1, 1, "R3");
    // R4: ramp down through band, reassert at resume
    for (int l = 40; l >= 0; l -= 2) cyc(l, 8'h48, 1, 0, 0, 1, 1, "R4");
    cyc(17, 8'h48, 1, 0, 0, 1, 1, "R4");
    for (int l = 20; l <= 34; l++) cyc(l, 8'h48, 1, 0, 0, 1, 1, "R4");
    for (int l = 31; l >= 15; l--) cyc(l, 8'h48, 1, 0, 0, 1, 1, "R4");

    // R5: resume 40 >= halt 24, single threshold
    for (int l = 18; l <= 30; l++) cyc(l, 8'hA6, 1, 0, 0, 1, 1, "R5");
    for (int l = 30; l >= 18; l--) cyc(l, 8'hA6, 1, 0, 0, 1, 1, "R5");
    cyc(24, 8'h66, 1, 0, 0, 1, 1, "R5");
    cyc(23, 8'h66, 1, 0, 0, 1, 1, "R5");

    // R10: halt code zero, never asserted
    for (int l = 0; l <= 64; l += 8) cyc(l, 8'h30, 1, 0, 1, 1, 1, "R10");

    // R6: manual mode and hysteresis clear
    cyc(40, 8'h48, 1, 0, 0, 1, 1, "R6");
    cyc(25, 8'h48, 1, 0, 0, 1, 1, "R6");
    cyc(25, 8'h48, 0, 0, 1, 1, 1, "R6");
    cyc(25, 8'h48, 0, 0, 0, 1, 1, "R6");
    cyc(25, 8'h48, 0, 0, 1, 1, 1, "R6");
    cyc(12, 8'h48, 1, 0, 0, 1, 1, "R6");
    cyc(25, 8'h48, 1, 0, 0, 1, 1, "R6");

    // R7: CTS latency through two stages
    cyc(0, 8'h48, 1, 1, 0, 1, 1, "R7");
    cyc(0, 8'h48, 1, 1, 0, 1, 1, "R7");
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R7");
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R7");
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R7");
    cyc(0, 8'h48, 1, 1, 0, 1, 1, "R7");
    cyc(0, 8'h48, 1, 1, 0, 1, 1, "R7");
    // R8: CTS drop mid-character, next start held off
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R8");
    cyc(0, 8'h48, 1, 1, 0, 0, 0, "R8");
    cyc(0, 8'h48, 1, 1, 0, 1, 0, "R8");
    cyc(0, 8'h48, 1, 1, 0, 1, 0, "R8");
    cyc(0, 8'h48, 1, 1, 0, 1, 1, "R8");
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R8");
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R8");
    cyc(0, 8'h48, 1, 1, 0, 0, 1, "R8");
    // R9: CTS ignored when gating off
    cyc(0, 8'h48, 1, 0, 0, 1, 0, "R9");
    cyc(0, 8'h48, 1, 0, 0, 1, 1, "R9");
    cyc(0, 8'h48, 1, 0, 0, 0, 0, "R9");

    // Mixed pseudo-random run against the model (R2 R3 R4 R5 R7 R8)
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[6:0] % 65, (i % 200 < 100) ? 8'h48 : {lfsr[15:12], lfsr[11:8]},
          (i % 97) != 5, (i % 300) < 250, lfsr[7], lfsr[8], lfsr[9], "R4");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule